// File: doc/BRIEF.md
# Comparator Output Conditioning and Event Detector

This block sits between a bank of analog comparators and the rest of a peripheral. Each channel takes the raw, asynchronous result of one comparator, optionally inverts it, and routes it two ways. The first route is a pin drive, which stays unsynchronized. The second is a synchronizer, which produces a status bit sampled on the peripheral clock. The synchronized, conditioned level also feeds an edge detector. A two-bit event selector picks which transitions count as events: none, upward only, downward only, or both. Every qualifying event sets a sticky per-channel interrupt request, and software clears it.

Because inversion comes before the edge detector, inverting a channel moves its events to the opposite raw edge. Three conditions stop a channel. It stops when its own enable is low. It stops when stop-in-idle is set and the system is idle. It stops when freeze is set and the CPU is halted for debug; in that case the whole block holds its state until the halt ends. Whenever a channel is enabled, or its inversion or event selection changes, the first synchronized sample is taken without raising an event.

Top module: `cmp_cond_top`

## Requirements
- R1: Event selector code 2'b00 never sets the channel's interrupt request.
- R2: Code 2'b01 sets the request on a 0-to-1 change of the conditioned level, 2'b10 on a 1-to-0 change, and 2'b11 on either change. The request rises SYNC_STAGES clock edges after the edge at which the raw input change is first captured.
- R3: With the invert bit at 1, the conditioned level is the complement of the raw input, so a 2'b01 selection fires on a falling raw input.
- R4: The pin enable for a running channel is 1 only when the channel's pin-enable bit is 1. While the pin enable is 1, the pin output equals the raw input XOR invert, with no clock delay. Otherwise the pin output is 0.
- R5: The status bit follows the conditioned level SYNC_STAGES clock edges after the raw change is captured, whether or not the pin is enabled.
- R6: The interrupt request is sticky and does not depend on any downstream enable. A clear input drops it, but an event arriving in the same cycle as a clear wins, and the request stays set.
- R7: With stop-in-idle at 1 and idle asserted, every channel holds its status, raises no events and drives no pin. With stop-in-idle at 0, idle has no effect.
- R8: With freeze at 1 and debug halt asserted, no status bit or interrupt request changes, and clear is ignored. Operation resumes when the halt ends.
- R9: A channel whose enable is 0 holds its status, raises no events and drives no pin.
- R10: In the first running cycle after a channel is enabled, and in any cycle where its invert bit or event selector differs from the previous cycle, the status bit updates but no event is raised.
- R11: After reset all status bits and interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_cmp | input | NUM_CH | Raw asynchronous comparator results |
| ch_on | input | NUM_CH | Per-channel enable |
| ch_inv | input | NUM_CH | Per-channel output inversion |
| ch_pin_en | input | NUM_CH | Per-channel pin drive enable |
| ch_evsel | input | 2*NUM_CH | Per-channel event selector, channel i in bits [2i+1:2i] |
| flag_clr | input | NUM_CH | Clear strobes for the interrupt requests |
| idle_stop | input | 1 | Stop all channels while idle |
| sys_idle | input | 1 | System is in idle |
| freeze_en | input | 1 | Freeze the block during debug halt |
| dbg_halt | input | 1 | CPU is halted in debug |
| pin_out | output | NUM_CH | Unsynchronized conditioned pin drive |
| pin_oe | output | NUM_CH | Pin drive enable |
| stat_out | output | NUM_CH | Synchronized conditioned status bits |
| irq | output | NUM_CH | Sticky interrupt requests |

## Verification
A software clear and a new event can reach the same channel's request in the same cycle. The bench provokes this by holding the clear strobe high while the raw input toggles, so some edges arrive exactly as a clear is applied. The behavioural model then expects the request to be set after that edge and dropped one cycle later. A configuration change can also coincide with an edge that the synchronizer is delivering. The bench flips the invert bit in the same cycle as a raw toggle and expects the status bit to move while the request stays untouched.

// File: rtl/cmp_cond_pkg.sv
package cmp_cond_pkg;
   typedef enum logic [1:0] {
      EV_NONE = 2'b00,
      EV_RISE = 2'b01,
      EV_FALL = 2'b10,
      EV_BOTH = 2'b11
   } ev_sel_e;

   localparam int unsigned EV_W = 2;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("cmp_sync needs at least two stages");
      end
   endgenerate

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q[s] <= 1'b0;
            end else if (!hold) begin
               if (s == 0) chain_q[s] <= d;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
   import cmp_cond_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hold,
   input  logic            active,
   input  logic            inv,
   input  logic [EV_W-1:0] evsel,
   input  logic            sync_bit,
   output logic            samp_o,
   output logic            evt_o
);
   localparam int unsigned CFG_W = EV_W + 1;

   logic [CFG_W-1:0] cfg_q;
   logic [CFG_W-1:0] cfg_now;
   logic             run_q;
   logic             samp_q;
   logic             cond;
   logic             rise;
   logic             fall;
   logic             quiet;
   logic             hit;

   assign cfg_now = {inv, evsel};
   assign cond    = sync_bit ^ inv;
   assign rise    = cond & ~samp_q;
   assign fall    = ~cond & samp_q;
   assign quiet   = ~run_q | (cfg_now != cfg_q);

   always_comb begin
      case (ev_sel_e'(evsel))
         EV_NONE: hit = 1'b0;
         EV_RISE: hit = rise;
         EV_FALL: hit = fall;
         default: hit = rise | fall;
      endcase
   end

   assign evt_o  = active & ~hold & ~quiet & hit;
   assign samp_o = samp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         run_q  <= 1'b0;
         samp_q <= 1'b0;
      end else if (!hold) begin
         cfg_q <= cfg_now;
         run_q <= active;
         if (active) samp_q <= cond;
      end
   end

   p_none_silent_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (ev_sel_e'(evsel) == EV_NONE) |-> !evt_o);

   p_cfg_quiet_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(hold) && !$stable(cfg_now)) |-> !evt_o);

   p_enable_quiet_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(hold) && !$past(active)) |-> !evt_o);
endmodule

// File: rtl/cmp_flag.sv
module cmp_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic set,
   input  logic clr,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
      end else if (!hold) begin
         if (set)      flag_o <= 1'b1;
         else if (clr) flag_o <= 1'b0;
      end
   end

   p_sticky_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr) |=> flag_o);

   p_set_wins_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (set && !hold) |=> flag_o);

   p_frozen_flag_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(flag_o));
endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
   import cmp_cond_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hold,
   input  logic            active,
   input  logic            raw,
   input  logic            inv,
   input  logic            pin_en,
   input  logic [EV_W-1:0] evsel,
   input  logic            clr,
   output logic            pin_out,
   output logic            pin_oe,
   output logic            stat,
   output logic            irq
);
   logic sync_bit;
   logic evt;

   assign pin_oe  = active & pin_en;
   assign pin_out = pin_oe & (raw ^ inv);

   cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (hold),
      .d     (raw),
      .q     (sync_bit)
   );

   cmp_edge_det u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (hold),
      .active   (active),
      .inv      (inv),
      .evsel    (evsel),
      .sync_bit (sync_bit),
      .samp_o   (stat),
      .evt_o    (evt)
   );

   cmp_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold   (hold),
      .set    (evt),
      .clr    (clr),
      .flag_o (irq)
   );

   p_off_no_event_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !clr) |=> $stable(irq));

   p_off_stat_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> $stable(stat));

   p_pin_quiet_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe |-> !pin_out);
endmodule

// File: rtl/cmp_cond_top.sv
module cmp_cond_top
   import cmp_cond_pkg::*;
#(
   parameter int unsigned NUM_CH      = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_CH-1:0]      raw_cmp,
   input  logic [NUM_CH-1:0]      ch_on,
   input  logic [NUM_CH-1:0]      ch_inv,
   input  logic [NUM_CH-1:0]      ch_pin_en,
   input  logic [EV_W*NUM_CH-1:0] ch_evsel,
   input  logic [NUM_CH-1:0]      flag_clr,
   input  logic                   idle_stop,
   input  logic                   sys_idle,
   input  logic                   freeze_en,
   input  logic                   dbg_halt,
   output logic [NUM_CH-1:0]      pin_out,
   output logic [NUM_CH-1:0]      pin_oe,
   output logic [NUM_CH-1:0]      stat_out,
   output logic [NUM_CH-1:0]      irq
);
   generate
      if (NUM_CH < 1) begin : g_bad_count
         $error("cmp_cond_top needs at least one channel");
      end
   endgenerate

   logic idle_off;
   logic frozen;

   assign idle_off = idle_stop & sys_idle;
   assign frozen   = freeze_en & dbg_halt;

   genvar i;
   generate
      for (i = 0; i < NUM_CH; i++) begin : g_ch
         cmp_channel #(.SYNC_STAGES(SYNC_STAGES)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .hold    (frozen),
            .active  (ch_on[i] & ~idle_off),
            .raw     (raw_cmp[i]),
            .inv     (ch_inv[i]),
            .pin_en  (ch_pin_en[i]),
            .evsel   (ch_evsel[EV_W*i +: EV_W]),
            .clr     (flag_clr[i]),
            .pin_out (pin_out[i]),
            .pin_oe  (pin_oe[i]),
            .stat    (stat_out[i]),
            .irq     (irq[i])
         );
      end
   endgenerate

   p_freeze_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      frozen |=> ($stable(stat_out) && $stable(irq)));

   p_idle_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      idle_off |=> $stable(stat_out));

   p_idle_no_pin_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      idle_off |-> (pin_oe == '0));
endmodule

// File: tb/cmp_cond_top_tb.sv
module cmp_cond_top_tb;
   localparam int NCH = 2;
   localparam int SS  = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] raw_cmp = '0;
   logic [NCH-1:0] ch_on = '0;
   logic [NCH-1:0] ch_inv = '0;
   logic [NCH-1:0] ch_pin_en = '0;
   logic [2*NCH-1:0] ch_evsel = '0;
   logic [NCH-1:0] flag_clr = '0;
   logic           idle_stop = 1'b0;
   logic           sys_idle = 1'b0;
   logic           freeze_en = 1'b0;
   logic           dbg_halt = 1'b0;
   logic [NCH-1:0] pin_out, pin_oe, stat_out, irq;

   cmp_cond_top #(.NUM_CH(NCH), .SYNC_STAGES(SS)) u_dut (
      .clk(clk), .rst_n(rst_n), .raw_cmp(raw_cmp), .ch_on(ch_on),
      .ch_inv(ch_inv), .ch_pin_en(ch_pin_en), .ch_evsel(ch_evsel),
      .flag_clr(flag_clr), .idle_stop(idle_stop), .sys_idle(sys_idle),
      .freeze_en(freeze_en), .dbg_halt(dbg_halt), .pin_out(pin_out),
      .pin_oe(pin_oe), .stat_out(stat_out), .irq(irq)
   );

   always #10 clk = ~clk;

   int    checks = 0;
   int    errors = 0;
   int    cycles = 0;
   bit    done = 1'b0;
   string tag = "R11 reset";
   logic [7:0] lfsr = 8'hA5;

   // behavioural model state
   bit    m_sync [NCH][$];
   bit    m_samp [NCH];
   bit    m_flag [NCH];
   bit    m_run  [NCH];
   int    m_cfg  [NCH];

   initial begin
      for (int c = 0; c < NCH; c++) begin
         m_sync[c] = {};
         for (int k = 0; k < SS; k++) m_sync[c].push_back(1'b0);
      end
   end

   always @(posedge clk) begin
      for (int c = 0; c < NCH; c++) begin
         if (!rst_n) begin
            for (int k = 0; k < SS; k++) m_sync[c][k] = 1'b0;
            m_samp[c] = 0; m_flag[c] = 0; m_run[c] = 0; m_cfg[c] = 0;
         end else if (!(freeze_en && dbg_halt)) begin
            bit act, lvl, quiet, ev;
            int cfg, sel;
            sel   = int'(ch_evsel[2*c +: 2]);
            cfg   = sel + 4 * int'(ch_inv[c]);
            act   = ch_on[c] && !(idle_stop && sys_idle);
            lvl   = m_sync[c][SS-1] ^ ch_inv[c];
            quiet = !m_run[c] || (cfg != m_cfg[c]);
            ev = 0;
            if (act && !quiet) begin
               if (sel == 1 && !m_samp[c] && lvl)  ev = 1;
               if (sel == 2 && m_samp[c] && !lvl)  ev = 1;
               if (sel == 3 && (m_samp[c] != lvl)) ev = 1;
            end
            if (act) m_samp[c] = lvl;
            if (ev) m_flag[c] = 1;
            else if (flag_clr[c]) m_flag[c] = 0;
            void'(m_sync[c].pop_back());
            m_sync[c].push_front(raw_cmp[c]);
            m_run[c] = act;
            m_cfg[c] = cfg;
         end
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         for (int c = 0; c < NCH; c++) begin
            bit act, eoe, epin;
            act  = ch_on[c] && !(idle_stop && sys_idle);
            eoe  = act && ch_pin_en[c];
            epin = eoe && (raw_cmp[c] ^ ch_inv[c]);
            checks++;
            if (stat_out[c] !== m_samp[c] || irq[c] !== m_flag[c] ||
                pin_oe[c] !== eoe || pin_out[c] !== epin) begin
               errors++;
               $display("FAIL %s ch%0d t=%0t: stat/irq/oe/pin actual %b%b%b%b expected %b%b%b%b",
                        tag, c, $time, stat_out[c], irq[c], pin_oe[c], pin_out[c],
                        m_samp[c], m_flag[c], eoe, epin);
            end
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired after %0d cycles", cycles);
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic cyc(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); #2;
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         raw_cmp[1] = lfsr[0];
      end
   endtask

   task automatic toggle0(input int times, input int gap);
      for (int k = 0; k < times; k++) begin
         raw_cmp[0] = ~raw_cmp[0];
         cyc(gap);
      end
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      ch_on[1] = 1'b1; ch_evsel[3:2] = 2'b11; ch_pin_en[1] = 1'b1;
      cyc(2);

      tag = "R9 channel off";
      toggle0(4, 3);

      tag = "R4 R2 rise select";
      ch_on[0] = 1'b1; ch_pin_en[0] = 1'b1; ch_evsel[1:0] = 2'b01;
      cyc(4);
      raw_cmp[0] = 1'b1; cyc(5);
      tag = "R6 clear";
      flag_clr = 2'b11; cyc(1); flag_clr = '0; cyc(2);
      tag = "R2 fall ignored under rise select";
      raw_cmp[0] = 1'b0; cyc(5);

      tag = "R2 fall select";
      ch_evsel[1:0] = 2'b10; cyc(3);
      raw_cmp[0] = 1'b1; cyc(4);
      raw_cmp[0] = 1'b0; cyc(4);
      flag_clr[0] = 1'b1; cyc(1); flag_clr[0] = 1'b0;

      tag = "R2 both select";
      ch_evsel[1:0] = 2'b11; cyc(3);
      raw_cmp[0] = 1'b1; cyc(4);
      flag_clr[0] = 1'b1; cyc(1); flag_clr[0] = 1'b0;
      raw_cmp[0] = 1'b0; cyc(4);
      flag_clr[0] = 1'b1; cyc(1); flag_clr[0] = 1'b0;

      tag = "R3 inverted rise select";
      ch_inv[0] = 1'b1; ch_evsel[1:0] = 2'b01; cyc(4);
      raw_cmp[0] = 1'b1; cyc(4);
      raw_cmp[0] = 1'b0; cyc(4);
      flag_clr[0] = 1'b1; cyc(1); flag_clr[0] = 1'b0;

      tag = "R1 events off";
      ch_evsel[1:0] = 2'b00; cyc(3);
      toggle0(6, 2);

      tag = "R6 clear meets event";
      ch_inv[0] = 1'b0; ch_evsel[1:0] = 2'b11; cyc(4);
      flag_clr = 2'b11;
      toggle0(8, 1);
      toggle0(4, 2);
      flag_clr = '0; cyc(3);

      tag = "R10 config change with edge";
      flag_clr = 2'b11; cyc(1); flag_clr = '0;
      raw_cmp[0] = ~raw_cmp[0]; cyc(SS);
      ch_inv[0] = 1'b1; cyc(4);
      raw_cmp[0] = ~raw_cmp[0]; ch_inv[0] = 1'b0; cyc(4);
      tag = "R10 enable with stale level";
      ch_on[0] = 1'b0; cyc(2);
      raw_cmp[0] = ~raw_cmp[0]; cyc(4);
      ch_on[0] = 1'b1; cyc(4);

      tag = "R7 idle with stop";
      idle_stop = 1'b1; sys_idle = 1'b1;
      toggle0(4, 3);
      tag = "R7 idle without stop";
      idle_stop = 1'b0;
      toggle0(4, 3);
      sys_idle = 1'b0; cyc(2);

      tag = "R8 freeze";
      freeze_en = 1'b1; dbg_halt = 1'b1;
      toggle0(3, 3);
      flag_clr = 2'b11; cyc(2); flag_clr = '0;
      tag = "R8 resume";
      dbg_halt = 1'b0; cyc(5);
      freeze_en = 1'b0;

      tag = "R5 status without pin";
      ch_pin_en = '0;
      toggle0(6, 3);
      cyc(4);

      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule